// File: doc/BRIEF.md
# Synchronous Phase-Frequency Detector with Lock Indicator

This block compares two divided strobes in an integer-N frequency synthesizer: the divided VCO strobe and the divided reference strobe. It works on a fast sampling clock. Both strobes are asynchronous to that clock, so each one passes through a flop synchronizer before its rising edge is detected. When the reference edge arrives first, the block drives an active-low "raise frequency" request. When the VCO edge arrives first, it drives an active-low "lower frequency" request. Each request lasts exactly as many sampling cycles as separate the two edges.

A lock indicator is built from the AND of the two active-low requests. That raw term is smoothed by a saturating run-length counter. An 8-bit control register is written through a parallel port. It provides power-down of the detector, a switch that silences the two strobe monitor outputs, and a priority mux that puts one of two internal test signals onto a single debug output.

Top module: `pfd_lock`

## Requirements
- R1: Only rising edges of `vco_strb` and `ref_strb` act on the detector. Steady levels and falling edges never pull `up_n` or `dn_n` low.
- R2: If the reference edge comes k sampling cycles before the VCO edge (k ≥ 1), `up_n` is low for exactly k cycles and `dn_n` stays high.
- R3: If the VCO edge comes k sampling cycles before the reference edge (k ≥ 1), `dn_n` is low for exactly k cycles and `up_n` stays high.
- R4: If both edges are seen in the same sampling cycle, neither output goes low. `up_n` and `dn_n` are never low together.
- R5: `lock` goes high once `up_n` and `dn_n` have both been high for LOCK_CYCLES (default 64) consecutive cycles. It goes low on the cycle after either of them is seen low.
- R6: Control bit 3 (power-down). While it is set, `up_n` and `dn_n` stay high, the detector state is cleared and `lock` is low. The register stays writable.
- R7: Control bit 7 forces `vco_mon` and `ref_mon` low. When it is clear, they follow the synchronized strobe levels.
- R8: Control bit 6 puts `presc_in` on `dbg_out`. Otherwise, control bit 5 puts `msel_in` on `dbg_out`. With neither bit set, `dbg_out` is 0. Bit 6 wins over bit 5.
- R9: Only control bits 3, 5, 6 and 7 are stored. `ctl_rdata` returns them in place, and every other bit reads 0.
- R10: After reset, `up_n` and `dn_n` are high, `lock` is low and `ctl_rdata` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| rst | input | 1 | Synchronous active-high reset |
| ctl_we | input | 1 | Control register write strobe |
| ctl_wdata | input | 8 | Control register write data |
| ctl_rdata | output | 8 | Control register read-back |
| vco_strb | input | 1 | Divided VCO strobe (asynchronous) |
| ref_strb | input | 1 | Divided reference strobe (asynchronous) |
| msel_in | input | 1 | Modulus-select test signal |
| presc_in | input | 1 | Raw prescaler test signal |
| up_n | output | 1 | Active-low raise-frequency request |
| dn_n | output | 1 | Active-low lower-frequency request |
| lock | output | 1 | Filtered lock indicator |
| vco_mon | output | 1 | Synchronized VCO strobe monitor |
| ref_mon | output | 1 | Synchronized reference strobe monitor |
| dbg_out | output | 1 | Debug test-signal output |

## Verification
A detector flag that sticks or clears at the wrong time shows up at once in the pulse widths. A request would be one cycle too long or too short, or it would never end. The bench therefore counts low cycles of each output over windows of known edge spacing, including equal spacing. A lock counter that saturates or clears wrongly only becomes visible after a window of about LOCK_CYCLES. It is therefore checked on both sides of that threshold, after reset and after each pulse. Errors in the control register show within one cycle of a write, on the read-back, the monitors or the debug pin.

// File: rtl/pfd_pkg.sv
package pfd_pkg;

    localparam int CTL_W       = 8;
    localparam int BIT_PD      = 3;
    localparam int BIT_MSEL    = 5;
    localparam int BIT_PRESC   = 6;
    localparam int BIT_MON_OFF = 7;

    typedef struct packed {
        logic mon_off;
        logic sel_presc;
        logic sel_msel;
        logic pd;
    } ctrl_t;

    typedef struct packed {
        logic ref_seen;
        logic vco_seen;
    } pfd_state_t;

    typedef enum logic [1:0] {
        DBG_ZERO  = 2'd0,
        DBG_MSEL  = 2'd1,
        DBG_PRESC = 2'd2
    } dbg_src_e;

    function automatic ctrl_t decode_ctrl(input logic [CTL_W-1:0] w);
        ctrl_t c;
        c.pd        = w[BIT_PD];
        c.sel_msel  = w[BIT_MSEL];
        c.sel_presc = w[BIT_PRESC];
        c.mon_off   = w[BIT_MON_OFF];
        return c;
    endfunction

    function automatic logic [CTL_W-1:0] encode_ctrl(input ctrl_t c);
        logic [CTL_W-1:0] w;
        w              = '0;
        w[BIT_PD]      = c.pd;
        w[BIT_MSEL]    = c.sel_msel;
        w[BIT_PRESC]   = c.sel_presc;
        w[BIT_MON_OFF] = c.mon_off;
        return w;
    endfunction

    function automatic dbg_src_e pick_dbg(input ctrl_t c);
        if (c.sel_presc)     return DBG_PRESC;
        else if (c.sel_msel) return DBG_MSEL;
        else                 return DBG_ZERO;
    endfunction

endpackage

// File: rtl/pfd_edge_sync.sv
module pfd_edge_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic din,
    output logic level,
    output logic rise
);
    logic [STAGES-1:0] chain;
    logic              prev;

    always_ff @(posedge clk) begin
        if (rst) begin
            chain <= '0;
            prev  <= 1'b0;
        end else begin
            chain <= {chain[STAGES-2:0], din};
            prev  <= chain[STAGES-1];
        end
    end

    assign level = chain[STAGES-1];
    assign rise  = chain[STAGES-1] & ~prev;
endmodule

// File: rtl/pfd_detect.sv
module pfd_detect
    import pfd_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic pd,
    input  logic ref_rise,
    input  logic vco_rise,
    output logic up_n,
    output logic dn_n
);
    pfd_state_t st;

    always_ff @(posedge clk) begin
        if (rst || pd) begin
            st <= '0;
        end else if (st.ref_seen && st.vco_seen) begin
            st <= '0;
        end else begin
            st.ref_seen <= st.ref_seen | ref_rise;
            st.vco_seen <= st.vco_seen | vco_rise;
        end
    end

    assign up_n = ~(st.ref_seen & ~st.vco_seen);
    assign dn_n = ~(st.vco_seen & ~st.ref_seen);
endmodule

// File: rtl/pfd_lock_filter.sv
module pfd_lock_filter #(
    parameter int LOCK_CYCLES = 64
) (
    input  logic clk,
    input  logic rst,
    input  logic pd,
    input  logic up_n,
    input  logic dn_n,
    output logic lock
);
    localparam int CW = $clog2(LOCK_CYCLES + 1);
    localparam logic [CW-1:0] LIMIT = CW'(LOCK_CYCLES);

    logic          raw;
    logic [CW-1:0] run_cnt;

    assign raw = up_n & dn_n;

    always_ff @(posedge clk) begin
        if (rst || pd || !raw) begin
            run_cnt <= '0;
        end else if (run_cnt != LIMIT) begin
            run_cnt <= run_cnt + 1'b1;
        end
    end

    assign lock = (run_cnt == LIMIT);
endmodule

// File: rtl/pfd_ctrl.sv
module pfd_ctrl
    import pfd_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             we,
    input  logic [CTL_W-1:0] wdata,
    input  logic             msel_in,
    input  logic             presc_in,
    output ctrl_t            cfg,
    output logic [CTL_W-1:0] rdata,
    output logic             dbg_out
);
    always_ff @(posedge clk) begin
        if (rst)     cfg <= '0;
        else if (we) cfg <= decode_ctrl(wdata);
    end

    assign rdata = encode_ctrl(cfg);

    always_comb begin
        unique case (pick_dbg(cfg))
            DBG_PRESC: dbg_out = presc_in;
            DBG_MSEL:  dbg_out = msel_in;
            default:   dbg_out = 1'b0;
        endcase
    end
endmodule

// File: rtl/pfd_lock.sv
module pfd_lock
    import pfd_pkg::*;
#(
    parameter int SYNC_STAGES = 2,
    parameter int LOCK_CYCLES = 64
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             ctl_we,
    input  logic [CTL_W-1:0] ctl_wdata,
    output logic [CTL_W-1:0] ctl_rdata,
    input  logic             vco_strb,
    input  logic             ref_strb,
    input  logic             msel_in,
    input  logic             presc_in,
    output logic             up_n,
    output logic             dn_n,
    output logic             lock,
    output logic             vco_mon,
    output logic             ref_mon,
    output logic             dbg_out
);
    localparam int NCH = 2;

    ctrl_t          cfg_q;
    logic [NCH-1:0] strb_in;
    logic [NCH-1:0] strb_lvl;
    logic [NCH-1:0] strb_rise;

    assign strb_in = {ref_strb, vco_strb};

    for (genvar ch = 0; ch < NCH; ch++) begin : g_sync
        pfd_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
            .clk   (clk),
            .rst   (rst),
            .din   (strb_in[ch]),
            .level (strb_lvl[ch]),
            .rise  (strb_rise[ch])
        );
    end

    pfd_ctrl u_ctrl (
        .clk      (clk),
        .rst      (rst),
        .we       (ctl_we),
        .wdata    (ctl_wdata),
        .msel_in  (msel_in),
        .presc_in (presc_in),
        .cfg      (cfg_q),
        .rdata    (ctl_rdata),
        .dbg_out  (dbg_out)
    );

    pfd_detect u_det (
        .clk      (clk),
        .rst      (rst),
        .pd       (cfg_q.pd),
        .ref_rise (strb_rise[1]),
        .vco_rise (strb_rise[0]),
        .up_n     (up_n),
        .dn_n     (dn_n)
    );

    pfd_lock_filter #(.LOCK_CYCLES(LOCK_CYCLES)) u_lock (
        .clk  (clk),
        .rst  (rst),
        .pd   (cfg_q.pd),
        .up_n (up_n),
        .dn_n (dn_n),
        .lock (lock)
    );

    assign vco_mon = strb_lvl[0] & ~cfg_q.mon_off;
    assign ref_mon = strb_lvl[1] & ~cfg_q.mon_off;
endmodule

// File: rtl/pfd_lock_chk.sv
module pfd_lock_chk
    import pfd_pkg::*;
(
    input logic             clk,
    input logic             rst,
    input logic [CTL_W-1:0] ctl_rdata,
    input logic             msel_in,
    input logic             presc_in,
    input logic             up_n,
    input logic             dn_n,
    input logic             lock,
    input logic             vco_mon,
    input logic             ref_mon,
    input logic             dbg_out
);
    a_r4_never_both_low: assert property (@(posedge clk) disable iff (rst)
        (up_n || dn_n));

    a_r5_lock_drops: assert property (@(posedge clk) disable iff (rst)
        (!up_n || !dn_n) |=> !lock);

    a_r6_powerdown_quiet: assert property (@(posedge clk) disable iff (rst)
        (ctl_rdata[BIT_PD] && $past(ctl_rdata[BIT_PD])) |-> (up_n && dn_n && !lock));

    a_r7_monitors_off: assert property (@(posedge clk) disable iff (rst)
        ctl_rdata[BIT_MON_OFF] |-> (!vco_mon && !ref_mon));

    a_r8_presc_priority: assert property (@(posedge clk) disable iff (rst)
        ctl_rdata[BIT_PRESC] |-> (dbg_out == presc_in));

    a_r8_msel_route: assert property (@(posedge clk) disable iff (rst)
        (ctl_rdata[BIT_MSEL] && !ctl_rdata[BIT_PRESC]) |-> (dbg_out == msel_in));

    a_r9_reserved_zero: assert property (@(posedge clk) disable iff (rst)
        (ctl_rdata[2:0] == 3'b000) && !ctl_rdata[4]);
endmodule

bind pfd_lock pfd_lock_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .ctl_rdata (ctl_rdata),
    .msel_in   (msel_in),
    .presc_in  (presc_in),
    .up_n      (up_n),
    .dn_n      (dn_n),
    .lock      (lock),
    .vco_mon   (vco_mon),
    .ref_mon   (ref_mon),
    .dbg_out   (dbg_out)
);

// File: tb/pfd_lock_bench.sv
module pfd_lock_bench;
    localparam int PERIOD = 10;
    localparam int LOCKN  = 64;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       ctl_we = 1'b0;
    logic [7:0] ctl_wdata = 8'h00;
    logic [7:0] ctl_rdata;
    logic       vco_strb = 1'b0, ref_strb = 1'b0;
    logic       msel_in = 1'b0, presc_in = 1'b0;
    logic       up_n, dn_n, lock, vco_mon, ref_mon, dbg_out;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #(PERIOD/2) clk = ~clk;

    pfd_lock #(.LOCK_CYCLES(LOCKN)) u_pfd_lock (
        .clk(clk), .rst(rst), .ctl_we(ctl_we), .ctl_wdata(ctl_wdata),
        .ctl_rdata(ctl_rdata), .vco_strb(vco_strb), .ref_strb(ref_strb),
        .msel_in(msel_in), .presc_in(presc_in), .up_n(up_n), .dn_n(dn_n),
        .lock(lock), .vco_mon(vco_mon), .ref_mon(ref_mon), .dbg_out(dbg_out)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(input logic [7:0] d);
        ctl_we = 1'b1; ctl_wdata = d;
        cyc(1);
        ctl_we = 1'b0; ctl_wdata = 8'h00;
    endtask

    // lead_ref=1: reference edge first; gap in cycles; returns low counts
    task automatic edge_pair(input bit lead_ref, input int gap,
                             output int up_lows, output int dn_lows);
        up_lows = 0; dn_lows = 0;
        if (lead_ref) ref_strb = 1'b1; else vco_strb = 1'b1;
        for (int i = 0; i < gap; i++) begin
            cyc(1);
            if (!up_n) up_lows++;
            if (!dn_n) dn_lows++;
        end
        if (lead_ref) vco_strb = 1'b1; else ref_strb = 1'b1;
        for (int i = 0; i < 12; i++) begin
            cyc(1);
            if (!up_n) up_lows++;
            if (!dn_n) dn_lows++;
        end
    endtask

    task automatic drop_strobes(output int lows);
        lows = 0;
        ref_strb = 1'b0;
        cyc(3);
        vco_strb = 1'b0;
        for (int i = 0; i < 8; i++) begin
            cyc(1);
            if (!up_n || !dn_n) lows++;
        end
    endtask

    task automatic t_reset;
        chk("R10 up_n", up_n, 1);
        chk("R10 dn_n", dn_n, 1);
        chk("R10 lock", lock, 0);
        chk("R10 rdata", ctl_rdata, 0);
    endtask

    task automatic t_lock_after_reset;
        cyc(LOCKN - 6);
        chk("R5 lock not yet", lock, 0);
        cyc(10);
        chk("R5 lock set", lock, 1);
    endtask

    task automatic t_up(input int gap);
        int u, d, f;
        edge_pair(1'b1, gap, u, d);
        chk("R2 up_n width", u, gap);
        chk("R2 dn_n quiet", d, 0);
        drop_strobes(f);
        chk("R1 falling edges ignored", f, 0);
    endtask

    task automatic t_dn(input int gap);
        int u, d, f;
        edge_pair(1'b0, gap, u, d);
        chk("R3 dn_n width", d, gap);
        chk("R3 up_n quiet", u, 0);
        drop_strobes(f);
        chk("R1 falling edges ignored", f, 0);
    endtask

    task automatic t_same;
        int u, d, f;
        edge_pair(1'b1, 0, u, d);
        chk("R4 same-cycle up_n", u, 0);
        chk("R4 same-cycle dn_n", d, 0);
        drop_strobes(f);
    endtask

    task automatic t_lock_relock;
        int u, d, f;
        cyc(LOCKN + 4);
        chk("R5 locked before pulse", lock, 1);
        edge_pair(1'b0, 5, u, d);
        chk("R5 lock dropped by pulse", lock, 0);
        drop_strobes(f);
        cyc(LOCKN - 30);
        chk("R5 not relocked early", lock, 0);
        cyc(20);
        chk("R5 relocked", lock, 1);
    endtask

    task automatic t_powerdown;
        int u, d, f;
        wr(8'h08);
        cyc(2);
        chk("R6 rdata pd", ctl_rdata, 8'h08);
        chk("R6 lock low", lock, 0);
        edge_pair(1'b1, 4, u, d);
        chk("R6 up_n held", u, 0);
        chk("R6 dn_n held", d, 0);
        drop_strobes(f);
        cyc(LOCKN + 4);
        chk("R6 lock stays low", lock, 0);
        wr(8'h00);
        edge_pair(1'b1, 3, u, d);
        chk("R6 detector back after pd", u, 3);
        drop_strobes(f);
    endtask

    task automatic t_monitors;
        vco_strb = 1'b1; ref_strb = 1'b0;
        cyc(4);
        chk("R7 vco_mon follows", vco_mon, 1);
        chk("R7 ref_mon follows", ref_mon, 0);
        wr(8'h80);
        chk("R7 vco_mon forced", vco_mon, 0);
        ref_strb = 1'b1;
        cyc(4);
        chk("R7 ref_mon forced", ref_mon, 0);
        wr(8'h00);
        chk("R7 ref_mon restored", ref_mon, 1);
        vco_strb = 1'b0; ref_strb = 1'b0;
        cyc(6);
    endtask

    task automatic t_debug;
        msel_in = 1'b1; presc_in = 1'b0;
        chk("R8 dbg zero", dbg_out, 0);
        wr(8'h20);
        chk("R8 dbg msel", dbg_out, 1);
        msel_in = 1'b0; #1;
        chk("R8 dbg msel low", dbg_out, 0);
        wr(8'h60);
        presc_in = 1'b1; msel_in = 1'b0; #1;
        chk("R8 presc priority hi", dbg_out, 1);
        presc_in = 1'b0; msel_in = 1'b1; #1;
        chk("R8 presc priority lo", dbg_out, 0);
        wr(8'h40);
        presc_in = 1'b1; #1;
        chk("R8 presc alone", dbg_out, 1);
        wr(8'h00);
        presc_in = 1'b0; msel_in = 1'b0;
    endtask

    task automatic t_readback;
        wr(8'hFF);
        chk("R9 readback all", ctl_rdata, 8'hE8);
        wr(8'h17);
        chk("R9 reserved read zero", ctl_rdata, 8'h00);
        wr(8'hA0);
        chk("R9 readback mix", ctl_rdata, 8'hA0);
        wr(8'h00);
        cyc(4);
    endtask

    initial begin
        cyc(3);
        rst = 1'b0;
        t_reset();
        t_lock_after_reset();
        t_up(1);
        t_up(3);
        t_up(7);
        t_dn(2);
        t_dn(5);
        t_same();
        t_lock_relock();
        t_powerdown();
        t_monitors();
        t_debug();
        t_readback();
        if (!done) begin
            done = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        #(PERIOD * 150000);
        if (!done) begin
            done = 1'b1;
            checks++;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end
endmodule